// File: doc/BRIEF.md
# ADC Conversion-Done Event Router

This block holds the status and request logic that sits between an analog-to-digital converter core and the rest of the chip. The core gives a one-cycle end-of-conversion pulse along with a 10-bit result. On that pulse the block latches the result and sets a sticky done flag. It then sends the event to one destination, chosen by two control bits: either a level interrupt to the CPU, or a level transfer request to a DMA controller.

With DMA steering selected, the DMA controller's one-cycle acknowledge clears both the request and the done flag in hardware. Conversions can then be drained back to back with no software involvement. With CPU steering selected, software must read the flag as 1 and then write 0 to clear it.

A small register port gives access to the block. Address 0 is the control/status word:
- bit 0 is the done flag,
- bit 1 is the event enable,
- bit 2 is the DMA select,
- all other bits read 0.

Address 1 returns the result, zero-extended. Any other address reads 0. Reads are combinational from the address.

Top module: `adc_evt_steer`

## Requirements
- R1: After synchronous active-high reset, the done flag, the event enable, the DMA select, the DMA request and the result register are all 0, and the interrupt output is 0.
- R2: The clock edge that samples eocPulse high sets the done flag (status bit 0) and loads convResult into the result register, which reads back at address 1 with codes 0x000 to 0x3FF.
- R3: irqOut is high exactly while the done flag is 1, the event enable (status bit 1) is 1 and the DMA select (status bit 2) is 0.
- R4: When eocPulse is sampled with event enable 1 and DMA select 1, dmaReq goes high after that edge and stays high until dmaAck is sampled.
- R5: A dmaAck sampled while dmaReq is high clears both dmaReq and the done flag on that edge.
- R6: Writing 0 to status bit 0 clears the flag only if the status word was read while the flag was 1, with no status write in between. Without that read, the write leaves the flag at 1. Writing 1 to bit 0 never sets the flag.
- R7: When an eocPulse is sampled in the same cycle as a hardware (acknowledge) or software clear, the done flag stays 1.
- R8: With DMA select 0 or event enable 0, a conversion end raises no DMA request.
- R9: Status bits 1 and 2 take the written values and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eocPulse | input | 1 | One-cycle end-of-conversion pulse from the converter core |
| convResult | input | 10 | Converted result, valid with eocPulse |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (arms the software clear) |
| addr | input | 2 | Register address |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Register read data for addr |
| irqOut | output | 1 | CPU interrupt request (level) |
| dmaReq | output | 1 | DMA transfer request (level) |
| dmaAck | input | 1 | One-cycle DMA acknowledge |

## Verification
The assertions check these rules on every cycle:
- a conversion end always leaves the flag set and the result latched;
- the flag rises only from a conversion end;
- a DMA request persists until it is acknowledged;
- an acknowledge without a concurrent conversion end clears the flag;
- no request arises under CPU steering.

Some behaviour depends on what happened earlier, so only the bench scenarios can show it:
- the read-before-clear rule, including the status write that cancels a prior read;
- the value written to the flag bit being ignored;
- the set-wins races;
- the interrupt level under each combination of enable and select.

// File: rtl/adc_evt_pkg.sv
package adc_evt_pkg;

  localparam int unsigned DataW = 10;
  localparam int unsigned RegW  = 16;
  localparam int unsigned AddrW = 2;

  localparam logic [AddrW-1:0] StatusAddr = 2'd0;
  localparam logic [AddrW-1:0] ResultAddr = 2'd1;

  localparam int unsigned FlagBit = 0;
  localparam int unsigned EnBit   = 1;
  localparam int unsigned DselBit = 2;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic loadResult;
    logic selStatus;
    logic selResult;
  } dpStrobe_t;

  // Control/status state exported to the read mux
  typedef struct packed {
    logic dmaSel;
    logic evtEn;
    logic doneFlag;
  } statusBits_t;

endpackage

// File: rtl/adc_evt_ctrl.sv
module adc_evt_ctrl
  import adc_evt_pkg::*;
#(
  parameter int unsigned AW = AddrW,
  parameter int unsigned RW = RegW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eocPulse,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [AW-1:0] addr,
  input  logic [RW-1:0] wrData,
  input  logic          dmaAck,
  output dpStrobe_t     strobe,
  output statusBits_t   status,
  output logic          irqOut,
  output logic          dmaReq
);

  logic doneFlag;
  logic evtEn;
  logic dmaSel;
  logic clearArmed;

  logic hitStatus;
  logic wrStatus;
  logic rdStatus;
  logic hwClear;
  logic swClear;
  logic flagNext;
  logic reqSet;

  assign hitStatus = (addr == StatusAddr[AW-1:0]);
  assign wrStatus  = wrEn && hitStatus;
  assign rdStatus  = rdEn && hitStatus;

  assign hwClear = dmaAck && dmaReq;
  assign swClear = wrStatus && !wrData[FlagBit] && clearArmed;
  assign reqSet  = eocPulse && evtEn && dmaSel;

  // A new conversion end always wins over any clear source
  always_comb begin
    if (eocPulse) begin
      flagNext = 1'b1;
    end else if (hwClear || swClear) begin
      flagNext = 1'b0;
    end else begin
      flagNext = doneFlag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      doneFlag <= 1'b0;
    end else begin
      doneFlag <= flagNext;
    end
  end

  // Read of the flag as 1 arms the software clear; any status write or a
  // flag that drops disarms it.
  always_ff @(posedge clk) begin
    if (rst) begin
      clearArmed <= 1'b0;
    end else if (!flagNext || wrStatus) begin
      clearArmed <= 1'b0;
    end else if (rdStatus && doneFlag) begin
      clearArmed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evtEn  <= 1'b0;
      dmaSel <= 1'b0;
    end else if (wrStatus) begin
      evtEn  <= wrData[EnBit];
      dmaSel <= wrData[DselBit];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dmaReq <= 1'b0;
    end else if (reqSet) begin
      dmaReq <= 1'b1;
    end else if (dmaAck) begin
      dmaReq <= 1'b0;
    end
  end

  assign irqOut = doneFlag && evtEn && !dmaSel;

  assign strobe.loadResult = eocPulse;
  assign strobe.selStatus  = hitStatus;
  assign strobe.selResult  = (addr == ResultAddr[AW-1:0]);

  assign status.doneFlag = doneFlag;
  assign status.evtEn    = evtEn;
  assign status.dmaSel   = dmaSel;

  AST_EOC_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    eocPulse |=> doneFlag) else $error("flag not set after eoc");  // R7

  AST_FLAG_RISE_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(doneFlag) |-> $past(eocPulse)) else $error("flag rose without eoc");  // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dmaReq && !dmaAck) |=> dmaReq) else $error("request dropped early");  // R4

  AST_REQ_RAISE: assert property (@(posedge clk) disable iff (rst)
    (eocPulse && evtEn && dmaSel) |=> dmaReq) else $error("request missing");  // R4

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (dmaAck && dmaReq && !eocPulse) |=> (!doneFlag && !dmaReq)) else $error("ack did not clear");  // R5

  AST_NO_REQ_CPU: assert property (@(posedge clk) disable iff (rst)
    (!dmaReq && !(evtEn && dmaSel)) |=> !dmaReq) else $error("request under cpu steering");  // R8

endmodule

// File: rtl/adc_evt_dp.sv
module adc_evt_dp
  import adc_evt_pkg::*;
#(
  parameter int unsigned DW = DataW,
  parameter int unsigned RW = RegW
) (
  input  logic          clk,
  input  logic          rst,
  input  dpStrobe_t     strobe,
  input  statusBits_t   status,
  input  logic [DW-1:0] convResult,
  output logic [RW-1:0] rdData
);

  localparam int unsigned PadW = RW - DW;

  logic [DW-1:0] resultReg;
  logic [RW-1:0] statusWord;
  logic [RW-1:0] resultWord;

  always_ff @(posedge clk) begin
    if (rst) begin
      resultReg <= '0;
    end else if (strobe.loadResult) begin
      resultReg <= convResult;
    end
  end

  always_comb begin
    statusWord          = '0;
    statusWord[FlagBit] = status.doneFlag;
    statusWord[EnBit]   = status.evtEn;
    statusWord[DselBit] = status.dmaSel;
  end

  generate
    if (PadW > 0) begin : g_pad
      assign resultWord = {{PadW{1'b0}}, resultReg};
    end else begin : g_nopad
      assign resultWord = resultReg[RW-1:0];
    end
  endgenerate

  always_comb begin
    if (strobe.selStatus) begin
      rdData = statusWord;
    end else if (strobe.selResult) begin
      rdData = resultWord;
    end else begin
      rdData = '0;
    end
  end

  AST_RESULT_LATCH: assert property (@(posedge clk) disable iff (rst)
    strobe.loadResult |=> (resultReg == $past(convResult))) else $error("result not latched");  // R2

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadResult |=> $stable(resultReg)) else $error("result changed without eoc");  // R2

endmodule

// File: rtl/adc_evt_steer.sv
module adc_evt_steer
  import adc_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             eocPulse,
  input  logic [DataW-1:0] convResult,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [AddrW-1:0] addr,
  input  logic [RegW-1:0]  wrData,
  output logic [RegW-1:0]  rdData,
  output logic             irqOut,
  output logic             dmaReq,
  input  logic             dmaAck
);

  dpStrobe_t   strobe;
  statusBits_t status;

  adc_evt_ctrl #(.AW(AddrW), .RW(RegW)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .eocPulse (eocPulse),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .addr     (addr),
    .wrData   (wrData),
    .dmaAck   (dmaAck),
    .strobe   (strobe),
    .status   (status),
    .irqOut   (irqOut),
    .dmaReq   (dmaReq)
  );

  adc_evt_dp #(.DW(DataW), .RW(RegW)) i_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .status     (status),
    .convResult (convResult),
    .rdData     (rdData)
  );

endmodule

// File: tb/test_adc_evt_steer.sv
module test_adc_evt_steer;

  localparam int ClkPeriod = 10;
  localparam int NumVec = 5;
  // {evtEn, dmaSel, expIrq, expReq}
  localparam logic [3:0] VecCfg [NumVec] = '{4'b0000, 4'b1010, 4'b1101, 4'b0100, 4'b1101};
  localparam logic [9:0] VecVal [NumVec] = '{10'h000, 10'h155, 10'h2AA, 10'h0F0, 10'h3FF};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        eocPulse = 1'b0;
  logic [9:0]  convResult = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irqOut;
  logic        dmaReq;
  logic        dmaAck = 1'b0;

  int testsRun = 0;
  int testsFailed = 0;
  logic [15:0] rv;

  always #(ClkPeriod/2) clk = ~clk;

  adc_evt_steer i_adc_evt_steer (
    .clk(clk), .rst(rst), .eocPulse(eocPulse), .convResult(convResult),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .irqOut(irqOut), .dmaReq(dmaReq), .dmaAck(dmaAck)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulseEoc(input logic [9:0] v);
    eocPulse = 1'b1; convResult = v;
    tick();
    eocPulse = 1'b0;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [15:0] d);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    tick();
    rdEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    #(ClkPeriod * 20000);
    testsRun++; testsFailed++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    tick(); tick();
    rst = 1'b0;
    // R1 reset state
    peek(2'd0, rv); chk("R1 status", rv, 16'h0000);
    peek(2'd1, rv); chk("R1 result", rv, 16'h0000);
    chk("R1 irq", {15'b0, irqOut}, 16'h0);
    chk("R1 req", {15'b0, dmaReq}, 16'h0);

    // Table of steering configurations
    for (int i = 0; i < NumVec; i++) begin
      logic en, ds, eIrq, eReq;
      {en, ds, eIrq, eReq} = VecCfg[i];
      wrReg(2'd0, {13'b0, ds, en, 1'b0});
      peek(2'd0, rv); chk("R9 ctl readback", rv, {13'b0, ds, en, 1'b0});
      pulseEoc(VecVal[i]);
      peek(2'd1, rv); chk("R2 result", rv, {6'b0, VecVal[i]});
      peek(2'd0, rv); chk("R2 flag", rv, {13'b0, ds, en, 1'b1});
      chk("R3 irq", {15'b0, irqOut}, {15'b0, eIrq});
      chk("R4 R8 req", {15'b0, dmaReq}, {15'b0, eReq});
      if (eReq) begin
        tick(); tick();
        chk("R4 req held", {15'b0, dmaReq}, 16'h1);
        dmaAck = 1'b1; tick(); dmaAck = 1'b0;
        chk("R5 req cleared", {15'b0, dmaReq}, 16'h0);
        peek(2'd0, rv); chk("R5 flag cleared", rv, {13'b0, ds, en, 1'b0});
      end else begin
        rdReg(2'd0, rv);
        wrReg(2'd0, {13'b0, ds, en, 1'b0});
        peek(2'd0, rv); chk("R6 sw clear", rv, {13'b0, ds, en, 1'b0});
        chk("R3 irq low after clear", {15'b0, irqOut}, 16'h0);
      end
    end

    // R6 write 0 without prior read is ignored
    wrReg(2'd0, 16'h0002);
    pulseEoc(10'h123);
    wrReg(2'd0, 16'h0002);
    peek(2'd0, rv); chk("R6 unarmed write", rv, 16'h0003);
    // R6 read, then a status write cancels the arming
    rdReg(2'd0, rv);
    wrReg(2'd0, 16'h0003);
    peek(2'd0, rv); chk("R6 write 1 keeps flag", rv, 16'h0003);
    wrReg(2'd0, 16'h0002);
    peek(2'd0, rv); chk("R6 disarmed by write", rv, 16'h0003);

    // R7 set wins over software clear
    rdReg(2'd0, rv);
    wrEn = 1'b1; addr = 2'd0; wrData = 16'h0002; eocPulse = 1'b1; convResult = 10'h0AB;
    tick();
    wrEn = 1'b0; eocPulse = 1'b0;
    peek(2'd0, rv); chk("R7 set beats sw clear", rv, 16'h0003);
    rdReg(2'd0, rv);
    wrReg(2'd0, 16'h0002);
    peek(2'd0, rv); chk("R6 cleared after reread", rv, 16'h0002);

    // R6 writing 1 to a clear flag does not set it
    wrReg(2'd0, 16'h0003);
    peek(2'd0, rv); chk("R6 write 1 no set", rv, 16'h0002);

    // R7 set wins over acknowledge
    wrReg(2'd0, 16'h0006);
    pulseEoc(10'h001);
    chk("R4 req up", {15'b0, dmaReq}, 16'h1);
    chk("R3 irq masked by dsel", {15'b0, irqOut}, 16'h0);
    dmaAck = 1'b1; eocPulse = 1'b1; convResult = 10'h002;
    tick();
    dmaAck = 1'b0; eocPulse = 1'b0;
    peek(2'd0, rv); chk("R7 set beats ack", rv, 16'h0007);
    peek(2'd1, rv); chk("R2 result updated", rv, 16'h0002);
    dmaAck = 1'b1; tick(); dmaAck = 1'b0;
    peek(2'd0, rv); chk("R5 final clear", rv, 16'h0006);

    // R8 enable off with dsel on: no request, no interrupt
    wrReg(2'd0, 16'h0004);
    pulseEoc(10'h3FF);
    chk("R8 no req", {15'b0, dmaReq}, 16'h0);
    chk("R3 no irq", {15'b0, irqOut}, 16'h0);

    // R1 reset clears everything again
    rst = 1'b1; tick(); rst = 1'b0;
    peek(2'd0, rv); chk("R1 status after reset", rv, 16'h0000);
    peek(2'd1, rv); chk("R1 result after reset", rv, 16'h0000);

    summary();
  end

endmodule